// File: doc/BRIEF.md
# AC-link Receive Deframer

This block turns the serial input stream of an audio codec link into whole frames. It runs on the bit clock that the codec supplies. It watches the sync line, which the controller drives high on a rising bit-clock edge, and it samples both sync and serial data on falling edges. The first data bit of a frame arrives one bit period after sync rises. Each frame is a tag element followed by a fixed number of equal-width slots, and every element is sent most significant bit first. The defaults are a 16-bit tag and twelve 20-bit slots, which make a 256-bit frame.

When the last slot bit has been captured, the block decodes the tag and presents one parallel bundle for one bit-clock period. The bundle holds the raw tag, the codec-ready flag, one valid flag per slot and every slot word. Slot words are passed through even when their valid flag is clear. If sync rises again before a frame is complete, the partial frame is dropped and an error pulse is raised instead.

Top module: `aclink_rx_deframer`

## Requirements
- R1: While `rst_n` is low, `frm_valid_o`, `frm_err_o` and every bundle output are 0.
- R2: `sync_in` and `sdin` are sampled only on falling edges of `bclk`, so data the codec changes on rising edges is captured without error.
- R3: The bit sampled at the falling edge one bit period after the edge at which sync was first seen high is the first bit (MSB) of the tag. `frm_tag_o` carries the tag with that bit at position TAG_W-1.
- R4: A frame is TAG_W + NSLOT*SLOT_W bits long. Capture stops after that many bits until the next sync rise, and a rise of `sync_in` while idle causes no error.
- R5: `codec_ready_o` equals tag bit TAG_W-1 of the published frame.
- R6: `slot_vld_o[s]` equals tag bit TAG_W-2-s. Slot 0 uses the bit right after the ready bit.
- R7: Slot s is the (s+1)-th element after the tag, received MSB first, and appears on `slot_data_o[s*SLOT_W +: SLOT_W]`.
- R8: `frm_valid_o` is high for exactly one falling-edge period. It rises at the falling edge that captures the last frame bit, and the bundle holds its value until the next published frame.
- R9: If sync rises while a frame is partly received (the last bit not being captured at that edge), the partial frame is not published. `frm_err_o` pulses for one period and capture restarts on the new frame.
- R10: The word of a slot whose valid flag is 0 is still presented unchanged on `slot_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Codec bit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync from the controller |
| sdin | input | 1 | Serial data from the codec |
| frm_valid_o | output | 1 | One-period strobe: a complete frame is on the bundle |
| frm_err_o | output | 1 | One-period strobe: a partial frame was dropped |
| frm_tag_o | output | TAG_W | Raw tag element of the last frame |
| codec_ready_o | output | 1 | Codec-ready flag from the tag |
| slot_vld_o | output | NSLOT | Per-slot valid flags from the tag |
| slot_data_o | output | NSLOT*SLOT_W | Slot words, slot s in bits s*SLOT_W upward |

## Verification
The bench builds the block with an 8-bit tag, four 6-bit slots and a 32-bit frame. In that size the five tag flag bits have only 32 combinations, so back-to-back frames sweep every ready and slot-valid pattern exhaustively. The short frame also makes it cheap to cut a frame off at its longest legal length and at its shortest, and to leave idle gaps. Every strobe is checked against the exact bit-clock period that the bench computes from the sync edge.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

    localparam int unsigned ACL_TAG_W  = 16;
    localparam int unsigned ACL_SLOT_W = 20;
    localparam int unsigned ACL_NSLOT  = 12;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_phase_e;

endpackage

// File: rtl/aclink_rx_sync_detect.sv
module aclink_rx_sync_detect (
    input  logic bclk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_rise
);

    typedef struct packed {
        logic prev;
    } sd_st_t;

    sd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        sync_rise = sync_in & ~st_q.prev;
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/aclink_rx_capture.sv
module aclink_rx_capture #(
    parameter int unsigned FRAME_BITS = 256
) (
    input  logic                  bclk,
    input  logic                  rst_n,
    input  logic                  sync_rise,
    input  logic                  sdin,
    output logic                  frame_done,
    output logic                  frame_abort,
    output logic [FRAME_BITS-1:0] frame_vec
);

    import aclink_rx_pkg::*;

    localparam int unsigned CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        cap_phase_e            phase;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-2:0] shreg;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        frame_done  = 1'b0;
        frame_abort = 1'b0;
        frame_vec   = {st_q.shreg, sdin};

        // the bit seen at this edge still belongs to the frame in progress
        if (st_q.phase == CAP_RUN) begin
            st_d.shreg = frame_vec[FRAME_BITS-2:0];
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) begin
                frame_done = 1'b1;
                st_d.phase = CAP_IDLE;
            end
        end

        // a new sync restarts capture; the next edge carries the first bit
        if (sync_rise) begin
            if ((st_q.phase == CAP_RUN) && (st_q.cnt != LAST_IDX)) begin
                frame_abort = 1'b1;
            end
            st_d.phase = CAP_RUN;
            st_d.cnt   = '0;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: CAP_IDLE, cnt: '0, shreg: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/aclink_rx_unpack.sv
module aclink_rx_unpack #(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20,
    parameter int unsigned NSLOT  = 12,
    localparam int unsigned FRAME_BITS = TAG_W + NSLOT * SLOT_W,
    localparam int unsigned SLOTS_W    = NSLOT * SLOT_W
) (
    input  logic [FRAME_BITS-1:0] frame_vec,
    output logic [TAG_W-1:0]      tag,
    output logic                  ready,
    output logic [NSLOT-1:0]      vld,
    output logic [SLOTS_W-1:0]    slots
);

    assign tag   = frame_vec[FRAME_BITS-1 -: TAG_W];
    assign ready = tag[TAG_W-1];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int unsigned TOP = FRAME_BITS - 1 - TAG_W - s * SLOT_W;
        assign vld[s]                     = tag[TAG_W-2-s];
        assign slots[s*SLOT_W +: SLOT_W]  = frame_vec[TOP -: SLOT_W];
    end

endmodule

// File: rtl/aclink_rx_deframer.sv
module aclink_rx_deframer #(
    parameter int unsigned TAG_W  = aclink_rx_pkg::ACL_TAG_W,
    parameter int unsigned SLOT_W = aclink_rx_pkg::ACL_SLOT_W,
    parameter int unsigned NSLOT  = aclink_rx_pkg::ACL_NSLOT
) (
    input  logic                    bclk,
    input  logic                    rst_n,
    input  logic                    sync_in,
    input  logic                    sdin,
    output logic                    frm_valid_o,
    output logic                    frm_err_o,
    output logic [TAG_W-1:0]        frm_tag_o,
    output logic                    codec_ready_o,
    output logic [NSLOT-1:0]        slot_vld_o,
    output logic [NSLOT*SLOT_W-1:0] slot_data_o
);

    localparam int unsigned FRAME_BITS = TAG_W + NSLOT * SLOT_W;
    localparam int unsigned SLOTS_W    = NSLOT * SLOT_W;

    typedef struct packed {
        logic               valid;
        logic               err;
        logic [TAG_W-1:0]   tag;
        logic               ready;
        logic [NSLOT-1:0]   vld;
        logic [SLOTS_W-1:0] slots;
    } out_st_t;

    logic                  sync_rise;
    logic                  frame_done;
    logic                  frame_abort;
    logic [FRAME_BITS-1:0] frame_vec;
    logic [TAG_W-1:0]      dec_tag;
    logic                  dec_ready;
    logic [NSLOT-1:0]      dec_vld;
    logic [SLOTS_W-1:0]    dec_slots;

    out_st_t out_d, out_q;

    aclink_rx_sync_detect u_sync (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sync_rise (sync_rise)
    );

    aclink_rx_capture #(
        .FRAME_BITS (FRAME_BITS)
    ) u_cap (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .sync_rise   (sync_rise),
        .sdin        (sdin),
        .frame_done  (frame_done),
        .frame_abort (frame_abort),
        .frame_vec   (frame_vec)
    );

    aclink_rx_unpack #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .NSLOT  (NSLOT)
    ) u_unpack (
        .frame_vec (frame_vec),
        .tag       (dec_tag),
        .ready     (dec_ready),
        .vld       (dec_vld),
        .slots     (dec_slots)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = frame_done;
        out_d.err   = frame_abort;
        if (frame_done) begin
            out_d.tag   = dec_tag;
            out_d.ready = dec_ready;
            out_d.vld   = dec_vld;
            out_d.slots = dec_slots;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign frm_valid_o   = out_q.valid;
    assign frm_err_o     = out_q.err;
    assign frm_tag_o     = out_q.tag;
    assign codec_ready_o = out_q.ready;
    assign slot_vld_o    = out_q.vld;
    assign slot_data_o   = out_q.slots;

endmodule

// File: rtl/aclink_rx_deframer_chk.sv
module aclink_rx_deframer_chk #(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20,
    parameter int unsigned NSLOT  = 12
) (
    input logic             bclk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             frm_valid_o,
    input logic             frm_err_o,
    input logic [TAG_W-1:0] frm_tag_o,
    input logic             codec_ready_o
);

    localparam int unsigned FRAME_BITS = TAG_W + NSLOT * SLOT_W;
    localparam int unsigned GAP_W      = $clog2(FRAME_BITS + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(FRAME_BITS);
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(FRAME_BITS - 1);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frm_valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R1
    always @(negedge bclk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!frm_valid_o && !frm_err_o);
        end
    end

    a_r8_valid_single: assert property (@(negedge bclk) disable iff (!rst_n)
        frm_valid_o |=> !frm_valid_o);

    a_r8_bundle_hold: assert property (@(negedge bclk) disable iff (!rst_n)
        !frm_valid_o |-> $stable(frm_tag_o));

    a_r8_frame_spacing: assert property (@(negedge bclk) disable iff (!rst_n)
        (frm_valid_o && seen_q) |-> (gap_q >= GAP_MIN));

    a_r5_ready_bit: assert property (@(negedge bclk) disable iff (!rst_n)
        frm_valid_o |-> (codec_ready_o == frm_tag_o[TAG_W-1]));

    a_r9_err_single: assert property (@(negedge bclk) disable iff (!rst_n)
        frm_err_o |=> !frm_err_o);

    a_r9_err_no_frame: assert property (@(negedge bclk) disable iff (!rst_n)
        frm_err_o |-> !frm_valid_o);

    a_r9_err_after_sync: assert property (@(negedge bclk) disable iff (!rst_n)
        frm_err_o |-> $past(sync_in));

endmodule

bind aclink_rx_deframer aclink_rx_deframer_chk #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .NSLOT  (NSLOT)
) u_chk (
    .bclk          (bclk),
    .rst_n         (rst_n),
    .sync_in       (sync_in),
    .frm_valid_o   (frm_valid_o),
    .frm_err_o     (frm_err_o),
    .frm_tag_o     (frm_tag_o),
    .codec_ready_o (codec_ready_o)
);

// File: tb/tb_aclink_rx_deframer.sv
module tb_aclink_rx_deframer;

    localparam int unsigned TAG_W   = 8;
    localparam int unsigned SLOT_W  = 6;
    localparam int unsigned NSLOT   = 4;
    localparam int unsigned FB      = TAG_W + NSLOT * SLOT_W;
    localparam int unsigned SLOTS_W = NSLOT * SLOT_W;
    localparam int unsigned SYNC_W  = 2;
    localparam int unsigned NFLAG   = NSLOT + 1;

    logic                 bclk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sync_in = 1'b0;
    logic                 sdin = 1'b0;
    logic                 frm_valid_o;
    logic                 frm_err_o;
    logic [TAG_W-1:0]     frm_tag_o;
    logic                 codec_ready_o;
    logic [NSLOT-1:0]     slot_vld_o;
    logic [SLOTS_W-1:0]   slot_data_o;

    int checks = 0;
    int errors = 0;
    int step_n = 0;
    logic carry_bit = 1'b0;
    bit finished = 1'b0;

    logic [TAG_W-1:0]   eq_tag  [0:63];
    logic [SLOTS_W-1:0] eq_sl   [0:63];
    int                 eq_step [0:63];
    int vw = 0, vr = 0;
    int                 ee_step [0:7];
    int ew = 0, er = 0;

    aclink_rx_deframer #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .NSLOT  (NSLOT)
    ) dut (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .sync_in       (sync_in),
        .sdin          (sdin),
        .frm_valid_o   (frm_valid_o),
        .frm_err_o     (frm_err_o),
        .frm_tag_o     (frm_tag_o),
        .codec_ready_o (codec_ready_o),
        .slot_vld_o    (slot_vld_o),
        .slot_data_o   (slot_data_o)
    );

    always #2 bclk = ~bclk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (step %0d)", req, what, act, exp, step_n);
        end
    endtask

    // one rising edge of the bit clock: the codec-side data changes here
    task automatic step(input logic s);
        @(posedge bclk);
        sync_in = s;
        sdin    = carry_bit;
        step_n++;
    endtask

    function automatic logic [FB-1:0] mk_frame(input logic [TAG_W-1:0] t,
                                               input logic [SLOTS_W-1:0] sl);
        logic [FB-1:0] f;
        f = '0;
        f[FB-1 -: TAG_W] = t;
        for (int s = 0; s < NSLOT; s++) begin
            f[FB-1-TAG_W-s*SLOT_W -: SLOT_W] = sl[s*SLOT_W +: SLOT_W];
        end
        return f;
    endfunction

    // nb = FB sends a whole frame; nb < FB cuts it short (next call must be a frame)
    task automatic send_frame(input logic [TAG_W-1:0] t, input logic [SLOTS_W-1:0] sl,
                              input int nb);
        logic [FB-1:0] f;
        f = mk_frame(t, sl);
        step(1'b1);
        for (int k = 0; k < FB - 1; k++) begin
            if (k >= nb) break;
            carry_bit = f[FB-1-k];
            step((k + 1) < SYNC_W);
        end
        if (nb == FB) begin
            carry_bit     = f[0];
            eq_tag[vw]    = t;
            eq_sl[vw]     = sl;
            eq_step[vw]   = step_n + 2;
            vw++;
        end else begin
            carry_bit     = 1'b0;
            ee_step[ew]   = step_n + 2;
            ew++;
        end
    endtask

    function automatic logic [SLOTS_W-1:0] mk_slots(input int n);
        logic [SLOTS_W-1:0] sl;
        for (int s = 0; s < NSLOT; s++) begin
            sl[s*SLOT_W +: SLOT_W] = SLOT_W'((n * 11 + s * 23 + 1) % (1 << SLOT_W));
        end
        return sl;
    endfunction

    function automatic logic [TAG_W-1:0] mk_tag(input int n);
        logic [TAG_W-1:0] t;
        t = TAG_W'(n * 3);
        t[TAG_W-1 -: NFLAG] = NFLAG'(n);
        return t;
    endfunction

    // output monitor, half way between falling edges
    logic [TAG_W-1:0] last_tag = '0;
    initial begin
        forever begin
            @(posedge bclk);
            #1;
            if (rst_n) begin
                if (vr < vw && eq_step[vr] == step_n) begin
                    logic [TAG_W-1:0]   et;
                    logic [SLOTS_W-1:0] es;
                    logic [NSLOT-1:0]   ev;
                    et = eq_tag[vr];
                    es = eq_sl[vr];
                    for (int s = 0; s < NSLOT; s++) ev[s] = et[TAG_W-2-s];
                    chk(frm_valid_o == 1'b1, "R8", "valid strobe at last bit", 64'(frm_valid_o), 64'd1);
                    chk(frm_tag_o == et, "R3", "tag alignment", 64'(frm_tag_o), 64'(et));
                    chk(codec_ready_o == et[TAG_W-1], "R5", "codec ready", 64'(codec_ready_o), 64'(et[TAG_W-1]));
                    chk(slot_vld_o == ev, "R6", "slot valid flags", 64'(slot_vld_o), 64'(ev));
                    chk(slot_data_o == es, "R7", "slot words (R2 falling-edge capture)", 64'(slot_data_o), 64'(es));
                    for (int s = 0; s < NSLOT; s++) begin
                        if (!ev[s]) begin
                            chk(slot_data_o[s*SLOT_W +: SLOT_W] == es[s*SLOT_W +: SLOT_W], "R10",
                                "invalid slot passed through", 64'(slot_data_o[s*SLOT_W +: SLOT_W]),
                                64'(es[s*SLOT_W +: SLOT_W]));
                        end
                    end
                    last_tag = et;
                    vr++;
                end else begin
                    if (frm_valid_o) chk(1'b0, "R8", "unexpected valid", 64'd1, 64'd0);
                    chk(frm_tag_o == last_tag, "R8", "bundle held", 64'(frm_tag_o), 64'(last_tag));
                end
                if (er < ew && ee_step[er] == step_n) begin
                    chk(frm_err_o == 1'b1, "R9", "error pulse on early sync", 64'(frm_err_o), 64'd1);
                    er++;
                end else if (frm_err_o) begin
                    chk(1'b0, "R4", "unexpected error pulse", 64'd1, 64'd0);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge bclk);
        #1;
        // R1 reset state
        chk(frm_valid_o == 1'b0 && frm_err_o == 1'b0, "R1", "strobes in reset",
            64'({frm_valid_o, frm_err_o}), 64'd0);
        chk(frm_tag_o == '0 && slot_data_o == '0 && slot_vld_o == '0 && codec_ready_o == 1'b0,
            "R1", "bundle in reset", 64'(slot_data_o), 64'd0);
        @(posedge bclk);
        rst_n = 1'b1;
        step(1'b0);
        step(1'b0);

        // R4: first sync from idle, then every flag pattern back to back
        for (int n = 0; n < (1 << NFLAG); n++) begin
            send_frame(mk_tag(n), mk_slots(n), FB);
        end

        // R9: cut one bit short of complete, then resume
        send_frame(mk_tag(5), mk_slots(40), FB - 2);
        send_frame(mk_tag(33), mk_slots(41), FB);

        // R9: cut right after the sync pulse
        send_frame(mk_tag(7), mk_slots(42), SYNC_W);
        send_frame(mk_tag(18), mk_slots(43), FB);

        // R4: idle gap after a complete frame raises no error
        repeat (5) begin
            carry_bit = (step_n % 2 == 0);
            step(1'b0);
        end
        send_frame(mk_tag(26), mk_slots(44), FB);
        send_frame(mk_tag(9), mk_slots(45), FB);
        repeat (6) step(1'b0);

        chk(vr == vw, "R8", "frames published", 64'(vr), 64'(vw));
        chk(er == ew, "R9", "error pulses seen", 64'(er), 64'(ew));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule